// File: doc/BRIEF.md
# GPIO Controller with Atomic Set/Clear

This block controls seventeen general-purpose pins through a small register bus made of an address, a write-data word, a write strobe and a combinational read-data word. Each pin has four configuration bits: output data, output enable (direction), pull-up enable and pull-down enable. A control that spans all seventeen pins is split into a low word for pins 15:0 and a high word whose bit 0 is pin 16. Output data and direction also have write-one-to-set and write-one-to-clear aliases, so software can change one bit without a read-modify-write. The pad level comes back through a two-flop synchronizer into an input register that software can read.

An open-drain output is made by holding the output data at 0 and toggling the direction bit. An open-source output holds the output data at 1 and toggles the direction bit. Pins in an analog-input alternate mode lose their pull-up. Pins in a reference-output or trace alternate mode lose both pulls. The configuration registers sit on a retention reset, which is separate from the core reset that clears the input path.

Top module: `gpio_ctrl`

## Requirements
- R1: After the retention reset, pad_oe_o, pad_out_o, pad_pu_o and pad_pd_o are all 0, so every pin is an input.
- R2: A write to address 0 loads output data bits 15:0. A write to address 1 loads bit 16 from wdata bit 0. The stored value reads back at the same address and drives pad_out_o one cycle after the write. With no write the value holds.
- R3: A write to address 2 (low) or 3 (high) sets every output data bit whose write bit is 1. The other bits keep their value.
- R4: A write to address 4 (low) or 5 (high) clears every output data bit whose write bit is 1. The other bits keep their value.
- R5: Direction (1 = output, shown on pad_oe_o) is loaded at addresses 6/7, set at 8/9 and cleared at 10/11, with the same semantics as R2 to R4.
- R6: Pull-up enables are at addresses 12/13 and pull-down enables at 14/15. They drive pad_pu_o and pad_pd_o.
- R7: pad_pu_o is 0 for every pin with alt_adc_i or alt_rt_i set. pad_pd_o is 0 for every pin with alt_rt_i set.
- R8: Address 16 reads the input level of pins 15:0 and address 17 reads pin 16 in bit 0. A pad change becomes visible after the third rising edge. A read of address 0 returns the stored data, not the pin level.
- R9: Set and clear aliases and unmapped addresses read 0. Bits 15:1 of every high word read 0, and writes to those bits are ignored.
- R10: A core reset alone clears the input register and leaves all configuration unchanged.
- R11: A read of a register in the same cycle as a write to it returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Core reset, active low, asynchronous |
| ret_rst_ni | input | 1 | Retention reset for configuration, active low |
| addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| pad_in_i | input | 17 | Pad levels |
| alt_adc_i | input | 17 | Pin is in an analog-input alternate mode |
| alt_rt_i | input | 17 | Pin is in a reference-output or trace alternate mode |
| pad_out_o | output | 17 | Output drive value |
| pad_oe_o | output | 17 | Output enable |
| pad_pu_o | output | 17 | Pull-up enable |
| pad_pd_o | output | 17 | Pull-down enable |

## Verification
A write and a read of the same register can fall in the same cycle because the read path is combinational. The bench drives a write to the output-data register while the same address is on the bus. It samples rdata_o before the clock edge and expects the old contents, then expects the new contents after the edge. A second overlap is a pad change racing a read of the input register. The bench reads the register after two edges and expects the old level, then reads it after the third edge and expects the new level.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 5;
  localparam int NREGS  = 4;
  typedef enum int {K_OUT = 0, K_DIR = 1, K_PU = 2, K_PD = 3} cfg_kind_e;

  localparam logic [ADDR_W-1:0] A_OUT_L = 5'd0;
  localparam logic [ADDR_W-1:0] A_SET_L = 5'd2;
  localparam logic [ADDR_W-1:0] A_CLR_L = 5'd4;
  localparam logic [ADDR_W-1:0] A_IN_L  = 5'd16;
  localparam logic [ADDR_W-1:0] A_IN_H  = 5'd17;

  // data word of register k; OUT and DIR carry set/clear aliases at +2..+5
  function automatic int reg_base(int k);
    return (k < 2) ? 6 * k : 12 + 2 * (k - 2);
  endfunction

  function automatic bit has_alias(int k);
    return k < 2;
  endfunction
endpackage

// File: rtl/gpio_wreg.sv
module gpio_wreg #(
  parameter int W     = 17,
  parameter int LOW_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic             set_lo_i,
  input  logic             set_hi_i,
  input  logic             clr_lo_i,
  input  logic             clr_hi_i,
  input  logic [LOW_W-1:0] wdata_i,
  output logic [W-1:0]     q_o
);
  localparam int HI_W = W - LOW_W;

  logic [W-1:0] lo_mask, hi_mask, val_lo, val_hi;
  logic [W-1:0] wr_mask, wr_val, set_v, clr_v, d;

  assign lo_mask = {{HI_W{1'b0}}, {LOW_W{1'b1}}};
  assign hi_mask = {{HI_W{1'b1}}, {LOW_W{1'b0}}};
  assign val_lo  = {{HI_W{1'b0}}, wdata_i};
  assign val_hi  = {wdata_i[HI_W-1:0], {LOW_W{1'b0}}};

  always_comb begin
    wr_mask = (wr_lo_i ? lo_mask : '0) | (wr_hi_i ? hi_mask : '0);
    wr_val  = wr_lo_i ? val_lo : val_hi;
    set_v   = (set_lo_i ? val_lo : '0) | (set_hi_i ? val_hi : '0);
    clr_v   = (clr_lo_i ? val_lo : '0) | (clr_hi_i ? val_hi : '0);
    // clear has priority over set
    d = ((q_o & ~wr_mask) | (wr_val & wr_mask) | set_v) & ~clr_v;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d;
  end

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_lo_i || wr_hi_i || set_lo_i || set_hi_i || clr_lo_i || clr_hi_i)
      |=> $stable(q_o));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 17
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      q_o  <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      q_o  <= s2_q;
    end
  end
endmodule

// File: rtl/gpio_pull_gate.sv
module gpio_pull_gate #(
  parameter int W = 17
) (
  input  logic [W-1:0] pu_i,
  input  logic [W-1:0] pd_i,
  input  logic [W-1:0] alt_adc_i,
  input  logic [W-1:0] alt_rt_i,
  output logic [W-1:0] pu_o,
  output logic [W-1:0] pd_o
);
  assign pu_o = pu_i & ~(alt_adc_i | alt_rt_i);
  assign pd_o = pd_i & ~alt_rt_i;
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int NPINS = 17,
  parameter int LOW_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ret_rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LOW_W-1:0]  wdata_i,
  input  logic              we_i,
  output logic [LOW_W-1:0]  rdata_o,
  input  logic [NPINS-1:0]  pad_in_i,
  input  logic [NPINS-1:0]  alt_adc_i,
  input  logic [NPINS-1:0]  alt_rt_i,
  output logic [NPINS-1:0]  pad_out_o,
  output logic [NPINS-1:0]  pad_oe_o,
  output logic [NPINS-1:0]  pad_pu_o,
  output logic [NPINS-1:0]  pad_pd_o
);
  localparam int HI_W = NPINS - LOW_W;

  logic [NPINS-1:0] cfg_q [NREGS];
  logic [NPINS-1:0] in_q;

  for (genvar k = 0; k < NREGS; k++) begin : g_cfg
    localparam int BASE = reg_base(k);
    logic wr_lo, wr_hi, set_lo, set_hi, clr_lo, clr_hi;
    assign wr_lo = we_i && (addr_i == ADDR_W'(BASE));
    assign wr_hi = we_i && (addr_i == ADDR_W'(BASE + 1));
    if (has_alias(k)) begin : g_alias
      assign set_lo = we_i && (addr_i == ADDR_W'(BASE + 2));
      assign set_hi = we_i && (addr_i == ADDR_W'(BASE + 3));
      assign clr_lo = we_i && (addr_i == ADDR_W'(BASE + 4));
      assign clr_hi = we_i && (addr_i == ADDR_W'(BASE + 5));
    end else begin : g_plain
      assign set_lo = 1'b0;
      assign set_hi = 1'b0;
      assign clr_lo = 1'b0;
      assign clr_hi = 1'b0;
    end
    gpio_wreg #(.W(NPINS), .LOW_W(LOW_W)) u_reg (
      .clk_i   (clk_i),
      .rst_ni  (ret_rst_ni),
      .wr_lo_i (wr_lo),
      .wr_hi_i (wr_hi),
      .set_lo_i(set_lo),
      .set_hi_i(set_hi),
      .clr_lo_i(clr_lo),
      .clr_hi_i(clr_hi),
      .wdata_i (wdata_i),
      .q_o     (cfg_q[k])
    );
  end

  gpio_in_sync #(.W(NPINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (in_q)
  );

  gpio_pull_gate #(.W(NPINS)) u_pull (
    .pu_i     (cfg_q[K_PU]),
    .pd_i     (cfg_q[K_PD]),
    .alt_adc_i(alt_adc_i),
    .alt_rt_i (alt_rt_i),
    .pu_o     (pad_pu_o),
    .pd_o     (pad_pd_o)
  );

  assign pad_out_o = cfg_q[K_OUT];
  assign pad_oe_o  = cfg_q[K_DIR];

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NREGS; k++) begin
      if (addr_i == ADDR_W'(reg_base(k)))
        rdata_o = cfg_q[k][LOW_W-1:0];
      else if (addr_i == ADDR_W'(reg_base(k) + 1))
        rdata_o[HI_W-1:0] = cfg_q[k][NPINS-1:LOW_W];
    end
    if (addr_i == A_IN_L) rdata_o = in_q[LOW_W-1:0];
    else if (addr_i == A_IN_H) rdata_o[HI_W-1:0] = in_q[NPINS-1:LOW_W];
  end

  p_set_r3: assert property (@(posedge clk_i) disable iff (!ret_rst_ni)
    (we_i && addr_i == A_SET_L)
      |=> ((pad_out_o[LOW_W-1:0] & $past(wdata_i)) == $past(wdata_i)));

  p_clr_r4: assert property (@(posedge clk_i) disable iff (!ret_rst_ni)
    (we_i && addr_i == A_CLR_L)
      |=> ((pad_out_o[LOW_W-1:0] & $past(wdata_i)) == '0));

  p_pu_off_r7: assert property (@(posedge clk_i) disable iff (!ret_rst_ni)
    (pad_pu_o & (alt_adc_i | alt_rt_i)) == '0);

  p_pd_off_r7: assert property (@(posedge clk_i) disable iff (!ret_rst_ni)
    (pad_pd_o & alt_rt_i) == '0);

  p_alias_rd_r9: assert property (@(posedge clk_i) disable iff (!ret_rst_ni)
    (addr_i == A_SET_L || addr_i == A_CLR_L) |-> rdata_o == '0);

  p_rd_old_r11: assert property (@(posedge clk_i) disable iff (!ret_rst_ni)
    (we_i && addr_i == A_OUT_L) |-> rdata_o == pad_out_o[LOW_W-1:0]);
endmodule

// File: tb/sim_gpio_ctrl.sv
module sim_gpio_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ret_rst_ni = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        we_i = 1'b0;
  logic [15:0] rdata_o;
  logic [16:0] pad_in_i = '0;
  logic [16:0] alt_adc_i = '0;
  logic [16:0] alt_rt_i = '0;
  logic [16:0] pad_out_o, pad_oe_o, pad_pu_o, pad_pd_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  gpio_ctrl u0 (.*);

  typedef struct packed {
    logic [3:0]  req;
    logic [4:0]  a;
    logic [15:0] d;
    logic [16:0] eo;
    logic [16:0] ed;
  } vec_t;

  // expected pad_out / pad_oe after each write, starting from reset
  localparam vec_t VECS [12] = '{
    '{4'd2, 5'd0,  16'hA5A5, 17'h0A5A5, 17'h00000},  // R2
    '{4'd2, 5'd1,  16'hFFFF, 17'h1A5A5, 17'h00000},  // R2, R9 upper bits ignored
    '{4'd3, 5'd2,  16'h0F00, 17'h1AFA5, 17'h00000},  // R3
    '{4'd4, 5'd4,  16'h00F0, 17'h1AF05, 17'h00000},  // R4
    '{4'd4, 5'd5,  16'h0001, 17'h0AF05, 17'h00000},  // R4
    '{4'd3, 5'd3,  16'hFFFE, 17'h0AF05, 17'h00000},  // R3 zeros keep
    '{4'd5, 5'd6,  16'h1234, 17'h0AF05, 17'h01234},  // R5
    '{4'd5, 5'd9,  16'h0001, 17'h0AF05, 17'h11234},  // R5
    '{4'd5, 5'd8,  16'h8001, 17'h0AF05, 17'h19235},  // R5
    '{4'd5, 5'd10, 16'h1004, 17'h0AF05, 17'h18231},  // R5
    '{4'd5, 5'd11, 16'h0001, 17'h0AF05, 17'h08231},  // R5
    '{4'd2, 5'd0,  16'h0000, 17'h00000, 17'h08231}   // R2
  };

  task automatic chk(string req, logic [16:0] act, logic [16:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
    #1;
  endtask

  task automatic rd(logic [4:0] a, output logic [15:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  initial begin
    logic [15:0] r;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1; ret_rst_ni = 1'b1;
    #1;
    chk("R1", pad_out_o, '0);
    chk("R1", pad_oe_o, '0);
    chk("R1", pad_pu_o, '0);
    chk("R1", pad_pd_o, '0);

    for (int i = 0; i < 12; i++) begin
      wr(VECS[i].a, VECS[i].d);
      chk($sformatf("R%0d out", VECS[i].req), pad_out_o, VECS[i].eo);
      chk($sformatf("R%0d oe", VECS[i].req), pad_oe_o, VECS[i].ed);
    end

    // R2 readback, R9 high word and alias reads
    wr(5'd0, 16'h5A5A);
    rd(5'd0, r); chk("R2", 17'(r), 17'h05A5A);
    wr(5'd3, 16'hFFFF);
    rd(5'd1, r); chk("R9", 17'(r), 17'h00001);
    rd(5'd2, r); chk("R9", 17'(r), 17'h0);
    rd(5'd11, r); chk("R9", 17'(r), 17'h0);
    rd(5'd20, r); chk("R9", 17'(r), 17'h0);
    rd(5'd7, r); chk("R9", 17'(r), 17'h0);

    // R11: same-cycle write and read
    @(negedge clk_i);
    addr_i = 5'd0; wdata_i = 16'h1111; we_i = 1'b1;
    #1; chk("R11", 17'(rdata_o), 17'h05A5A);
    @(negedge clk_i);
    we_i = 1'b0;
    #1; chk("R11", 17'(rdata_o), 17'h01111);

    // R6 pulls
    wr(5'd12, 16'h00FF);
    wr(5'd13, 16'h0001);
    wr(5'd14, 16'hFF00);
    chk("R6", pad_pu_o, 17'h100FF);
    chk("R6", pad_pd_o, 17'h0FF00);
    rd(5'd13, r); chk("R6", 17'(r), 17'h00001);

    // R7 alternate-mode gating
    alt_adc_i = 17'h00003; alt_rt_i = 17'h00300;
    #1;
    chk("R7", pad_pu_o, 17'h100FC);
    chk("R7", pad_pd_o, 17'h0FC00);

    // R8 input path latency
    @(negedge clk_i);
    pad_in_i = 17'h1ABCD;
    repeat (2) @(negedge clk_i);
    rd(5'd16, r); chk("R8 early", 17'(r), 17'h0);
    @(negedge clk_i);
    rd(5'd16, r); chk("R8", 17'(r), 17'h0ABCD);
    rd(5'd17, r); chk("R8", 17'(r), 17'h00001);
    rd(5'd0, r); chk("R8 out", 17'(r), 17'h01111);

    // R10 core reset keeps configuration
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    rd(5'd16, r); chk("R10", 17'(r), 17'h0);
    chk("R10", pad_out_o, 17'h11111);
    chk("R10", pad_pu_o, 17'h100FC);

    // R1 retention reset clears configuration
    @(negedge clk_i);
    ret_rst_ni = 1'b0;
    #1;
    chk("R1", pad_out_o, '0);
    chk("R1", pad_oe_o, '0);
    @(negedge clk_i);
    ret_rst_ni = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule